// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds the single reservation that a load-linked access opens, and it decides whether the store-conditional that follows may write memory. A load-linked strobe with a word-aligned address arms the reservation and records that address. The reservation then stays armed until something kills it. The kill events are:

- a write by another agent seen on the snoop port;
- an exception;
- a taken branch;
- any other memory access;
- more than the allowed number of retired instructions.

When a store-conditional strobe arrives, the block raises a grant in the same cycle if the reservation is still live and matches the store's word. The grant gates the real memory write, and a one-bit result that equals the grant is handed back for register write-back. Every store-conditional consumes the reservation, whether it succeeds or fails.

Snoop comparison is set at elaboration time. It can match on the exact word, or on the whole page that holds the reserved word; the page size is a parameter. The store-conditional's own address is always compared at word precision. An address whose low two bits are nonzero raises a misalignment flag. A misaligned load-linked arms nothing, and a misaligned store-conditional is always denied.

Top module: `llsc_resv_monitor`

## Requirements
- R1: An `ll_req` strobe whose address has bits [1:0] equal to 0 arms the reservation from the next cycle and records that full address. A misaligned `ll_req` leaves the reservation disarmed.
- R2: `sc_grant` and `sc_result` are 1 in a cycle only when all of these hold: `sc_req` is high, the reservation is armed, `sc_addr[ADDR_W-1:2]` equals the recorded address's bits [ADDR_W-1:2], `sc_addr[1:0]` is 0, and no kill event is present in that same cycle. Otherwise both are 0, including in every cycle without `sc_req`.
- R3: Every `sc_req` disarms the reservation, whether it was granted or not. A second store-conditional without a new load-linked is denied.
- R4: A snoop write whose address matches the reservation disarms it. Only addresses are compared, never data. A matching snoop in the same cycle as `sc_req` denies the store.
- R5: `exc_evt`, `br_taken_evt` and `mem_op_evt` each disarm the reservation. Any of them in the same cycle as `sc_req` denies the store.
- R6: Retire pulses are counted from the last load-linked. Up to 512 keep the reservation armed. The pulse that would make the count 513 kills it, and a retire pulse in the store-conditional's own cycle counts toward the total.
- R7: With `SNOOP_GRAN` = word, the snoop compares bits [ADDR_W-1:2]. With `SNOOP_GRAN` = page, it compares bits [ADDR_W-1:PAGE_BITS], where PAGE_BITS defaults to 12, so any write in the same 4 KB page kills the reservation.
- R8: `misalign` is 1 in any cycle where `ll_req` or `sc_req` is high with address bits [1:0] nonzero. A misaligned `sc_req` is never granted.
- R9: A load-linked that no store-conditional follows is legal. With no kill event, the reservation stays armed for any number of idle cycles.
- R10: A store-conditional to a word other than the reserved one is denied and disarms the reservation.
- R11: Reset disarms the reservation and zeroes the retire count. A store-conditional after reset is denied.
- R12: When `ll_req` coincides with a kill event, the load-linked wins: the new reservation is armed and its retire count starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_req | input | 1 | Load-linked strobe |
| ll_addr | input | ADDR_W | Load-linked byte address |
| sc_req | input | 1 | Store-conditional strobe |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| wr_snoop_vld | input | 1 | Write by another agent is visible this cycle |
| wr_snoop_addr | input | ADDR_W | Address of the snooped write |
| exc_evt | input | 1 | Exception pulse |
| br_taken_evt | input | 1 | Taken-branch pulse |
| mem_op_evt | input | 1 | Pulse for any other memory access |
| retire_evt | input | 1 | Instruction-retire pulse |
| sc_grant | output | 1 | Store-conditional may write memory (combinational) |
| sc_result | output | 1 | Success bit for register write-back (combinational) |
| misalign | output | 1 | Strobed address is not word-aligned |

## Verification
The properties assume two things about the inputs: every strobe is a single-cycle level with known values once reset is released, and `ll_req` and `sc_req` never rise in the same cycle. The clearing checks are still guarded with `!ll_req` so that they stay valid if the second assumption is broken. The stimulus keeps to these rules by driving every input through one task that changes the inputs only at the falling edge. The load-linked and store-conditional strobes go to separate cycles in every sweep. The sweeps cover all combinations of snoop kind (same word, same page, other page, none), exception, branch, memory access, retire, and same-cycle store-conditional. Each vector runs against a word-granular instance and a page-granular instance together.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    // Byte-offset bits below a word.
    localparam int WORD_LSB = 2;

    // Granularity used when comparing snooped writes with the reservation.
    typedef enum logic {
        GRAN_WORD = 1'b0,
        GRAN_PAGE = 1'b1
    } gran_e;

    // One bit per reason that can kill the reservation in a cycle.
    typedef struct packed {
        logic snoop;
        logic exc;
        logic branch;
        logic mem;
        logic expire;
    } kill_t;

endpackage

// File: rtl/llsc_addr_match.sv
// Compares two byte addresses above bit LSB; lower bits are masked away.
module llsc_addr_match #(
    parameter int ADDR_W = 32,
    parameter int LSB    = 2
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] CMP_MASK = {ADDR_W{1'b1}} << LSB;

    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff = addr_a ^ addr_b;
        hit  = ((diff & CMP_MASK) == '0);
    end
endmodule

// File: rtl/llsc_align_chk.sv
// Word alignment test on the byte-offset bits of an address.
module llsc_align_chk (
    input  logic [llsc_pkg::WORD_LSB-1:0] low_bits,
    output logic                          aligned
);
    always_comb begin
        aligned = (low_bits == '0);
    end
endmodule

// File: rtl/llsc_retire_ctr.sv
// Counts retire pulses since the last clear. expire is high when the count
// including this cycle's pulse goes beyond LIMIT. The count saturates at LIMIT+1.
module llsc_retire_ctr #(
    parameter int LIMIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW:0]   LIMIT_X = (CW + 1)'(LIMIT);
    localparam logic [CW-1:0] SAT     = CW'(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t        ctr_d, ctr_q;
    logic [CW:0] sum;

    always_comb begin
        sum    = {1'b0, ctr_q.cnt} + {{CW{1'b0}}, inc};
        expire = (sum > LIMIT_X);
        ctr_d  = ctr_q;
        if (clear) begin
            ctr_d.cnt = '0;
        end else if (expire) begin
            ctr_d.cnt = SAT;
        end else begin
            ctr_d.cnt = sum[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
    parameter int              ADDR_W       = 32,
    parameter int              PAGE_BITS    = 12,
    parameter int              RETIRE_LIMIT = 512,
    parameter llsc_pkg::gran_e SNOOP_GRAN   = llsc_pkg::GRAN_WORD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_req,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              wr_snoop_vld,
    input  logic [ADDR_W-1:0] wr_snoop_addr,
    input  logic              exc_evt,
    input  logic              br_taken_evt,
    input  logic              mem_op_evt,
    input  logic              retire_evt,
    output logic              sc_grant,
    output logic              sc_result,
    output logic              misalign
);
    import llsc_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } resv_t;

    resv_t resv_d, resv_q;
    kill_t kill;
    logic  any_kill;
    logic  snoop_hit, sc_hit;
    logic  ll_aligned, sc_aligned;
    logic  ctr_expire;
    logic  sc_ok;

    // Snoop comparator: the granularity parameter picks the compare width.
    generate
        if (SNOOP_GRAN == GRAN_PAGE) begin : g_snoop_page
            llsc_addr_match #(.ADDR_W(ADDR_W), .LSB(PAGE_BITS)) u_snoop_match (
                .addr_a (wr_snoop_addr),
                .addr_b (resv_q.addr),
                .hit    (snoop_hit)
            );
        end else begin : g_snoop_word
            llsc_addr_match #(.ADDR_W(ADDR_W), .LSB(WORD_LSB)) u_snoop_match (
                .addr_a (wr_snoop_addr),
                .addr_b (resv_q.addr),
                .hit    (snoop_hit)
            );
        end
    endgenerate

    // The store-conditional address is always compared at word precision.
    llsc_addr_match #(.ADDR_W(ADDR_W), .LSB(WORD_LSB)) u_sc_match (
        .addr_a (sc_addr),
        .addr_b (resv_q.addr),
        .hit    (sc_hit)
    );

    llsc_align_chk u_ll_align (
        .low_bits (ll_addr[WORD_LSB-1:0]),
        .aligned  (ll_aligned)
    );

    llsc_align_chk u_sc_align (
        .low_bits (sc_addr[WORD_LSB-1:0]),
        .aligned  (sc_aligned)
    );

    llsc_retire_ctr #(.LIMIT(RETIRE_LIMIT)) u_retire_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ll_req),
        .inc    (retire_evt),
        .expire (ctr_expire)
    );

    always_comb begin
        kill        = '0;
        kill.snoop  = wr_snoop_vld & resv_q.valid & snoop_hit;
        kill.exc    = exc_evt;
        kill.branch = br_taken_evt;
        kill.mem    = mem_op_evt;
        kill.expire = ctr_expire;
        any_kill    = |kill;

        sc_ok     = sc_req & resv_q.valid & sc_hit & sc_aligned & ~any_kill;
        sc_grant  = sc_ok;
        sc_result = sc_ok;
        misalign  = (ll_req & ~ll_aligned) | (sc_req & ~sc_aligned);

        resv_d = resv_q;
        if (ll_req) begin
            resv_d.valid = ll_aligned;
            resv_d.addr  = ll_addr;
        end else if (sc_req || any_kill) begin
            resv_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resv_q <= '0;
        end else begin
            resv_q <= resv_d;
        end
    end
endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ll_req,
    input logic [ADDR_W-1:0] ll_addr,
    input logic              sc_req,
    input logic [ADDR_W-1:0] sc_addr,
    input logic              wr_snoop_vld,
    input logic [ADDR_W-1:0] wr_snoop_addr,
    input logic              exc_evt,
    input logic              br_taken_evt,
    input logic              mem_op_evt,
    input logic              sc_grant,
    input logic              sc_result,
    input logic              misalign,
    input logic              resv_valid,
    input logic [ADDR_W-1:0] resv_addr
);
    // R1: an aligned load-linked arms the reservation with its address
    p_ll_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_req && ll_addr[1:0] == 2'b00) |=> (resv_valid && resv_addr == $past(ll_addr)));

    // R2: a grant needs a live reservation on the same word
    p_grant_needs_resv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sc_grant |-> (sc_req && resv_valid && sc_addr[ADDR_W-1:2] == resv_addr[ADDR_W-1:2]));

    // R2: no success result without a store-conditional strobe
    p_result_needs_sc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sc_result |-> sc_req);

    // R3: every store-conditional consumes the reservation
    p_sc_consumes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !ll_req) |=> !resv_valid);

    // R4: an exact-address snoop write kills the reservation
    p_snoop_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_snoop_vld && resv_valid && wr_snoop_addr == resv_addr && !ll_req) |=> !resv_valid);

    // R4: a same-cycle snoop hit beats the store-conditional
    p_snoop_beats_sc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_snoop_vld && resv_valid && wr_snoop_addr == resv_addr) |-> !sc_grant);

    // R5: exception, taken branch or memory access kills the reservation
    p_evt_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((exc_evt || br_taken_evt || mem_op_evt) && !ll_req) |=> !resv_valid);

    // R5: such an event in the store's own cycle denies it
    p_evt_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_evt || br_taken_evt || mem_op_evt) |-> !sc_grant);

    // R8: a misaligned store-conditional is flagged and denied
    p_sc_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && sc_addr[1:0] != 2'b00) |-> (misalign && !sc_grant));
endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(.ADDR_W(ADDR_W)) u_llsc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ll_req        (ll_req),
    .ll_addr       (ll_addr),
    .sc_req        (sc_req),
    .sc_addr       (sc_addr),
    .wr_snoop_vld  (wr_snoop_vld),
    .wr_snoop_addr (wr_snoop_addr),
    .exc_evt       (exc_evt),
    .br_taken_evt  (br_taken_evt),
    .mem_op_evt    (mem_op_evt),
    .sc_grant      (sc_grant),
    .sc_result     (sc_result),
    .misalign      (misalign),
    .resv_valid    (resv_q.valid),
    .resv_addr     (resv_q.addr)
);

// File: tb/llsc_resv_monitor_bench.sv
`timescale 1ns/1ps
module llsc_resv_monitor_bench;
    localparam int LIMIT = 512;
    localparam logic [31:0] A      = 32'h0000_5A40;
    localparam logic [31:0] A_WORD = 32'h0000_5A50; // same page, other word
    localparam logic [31:0] A_PAGE = 32'h0000_6A40; // other page

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ll_req = 0, sc_req = 0, snv = 0, exc = 0, br = 0, mem = 0, ret = 0;
    logic [31:0] ll_addr = '0, sc_addr = '0, sn_addr = '0;
    logic        g_w, r_w, m_w, g_p, r_p, m_p;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Independent model: one reservation per instance, shared retire count.
    logic        mv [2];
    logic [31:0] ma [2];
    int          mc;

    always #2 clk = ~clk;

    llsc_resv_monitor u_llsc_resv_monitor (
        .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .ll_addr(ll_addr),
        .sc_req(sc_req), .sc_addr(sc_addr), .wr_snoop_vld(snv), .wr_snoop_addr(sn_addr),
        .exc_evt(exc), .br_taken_evt(br), .mem_op_evt(mem), .retire_evt(ret),
        .sc_grant(g_w), .sc_result(r_w), .misalign(m_w));

    llsc_resv_monitor #(.SNOOP_GRAN(llsc_pkg::GRAN_PAGE)) u_llsc_resv_monitor_pg (
        .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .ll_addr(ll_addr),
        .sc_req(sc_req), .sc_addr(sc_addr), .wr_snoop_vld(snv), .wr_snoop_addr(sn_addr),
        .exc_evt(exc), .br_taken_evt(br), .mem_op_evt(mem), .retire_evt(ret),
        .sc_grant(g_p), .sc_result(r_p), .misalign(m_p));

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, check the combinational
    // outputs of both instances against the model, then advance the model.
    task automatic step(input logic llv, input logic [31:0] lla,
                        input logic scv, input logic [31:0] sca,
                        input logic sv, input logic [31:0] sa,
                        input logic e, input logic b, input logic m, input logic r,
                        input string tag);
        logic expire;
        @(negedge clk);
        ll_req = llv; ll_addr = lla; sc_req = scv; sc_addr = sca;
        snv = sv; sn_addr = sa; exc = e; br = b; mem = m; ret = r;
        #1;
        expire = (mc + int'(r)) > LIMIT;
        for (int i = 0; i < 2; i++) begin
            int   lsb;
            logic shit, kill, eg, em;
            lsb  = (i == 0) ? 2 : 12;
            shit = sv && mv[i] && ((sa >> lsb) == (ma[i] >> lsb));
            kill = shit || e || b || m || expire;
            eg   = scv && mv[i] && (sca[1:0] == 2'b00) && ((sca >> 2) == (ma[i] >> 2)) && !kill;
            em   = (llv && lla[1:0] != 2'b00) || (scv && sca[1:0] != 2'b00);
            if (i == 0) begin
                chk(tag, "word sc_grant", g_w, eg);
                chk(tag, "word sc_result", r_w, eg);
                chk(tag, "word misalign", m_w, em);
            end else begin
                chk(tag, "page sc_grant", g_p, eg);
                chk(tag, "page sc_result", r_p, eg);
                chk(tag, "page misalign", m_p, em);
            end
            if (llv) begin
                mv[i] = (lla[1:0] == 2'b00);
                ma[i] = lla;
            end else if (scv || kill) begin
                mv[i] = 1'b0;
            end
        end
        if (llv) mc = 0;
        else if (expire) mc = LIMIT + 1;
        else mc = mc + int'(r);
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, '0, 0, '0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        mv[0] = 0; mv[1] = 0; ma[0] = '0; ma[1] = '0; mc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset leaves no reservation; store fails
        step(0, '0, 1, A, 0, '0, 0, 0, 0, 0, "R11");
        chk("R11", "grant after reset", g_w, 1'b0);

        // R1 / R2: basic success, then R3: second store fails
        step(1, A, 0, '0, 0, '0, 0, 0, 0, 0, "R1");
        step(0, '0, 1, A, 0, '0, 0, 0, 0, 0, "R2");
        step(0, '0, 1, A, 0, '0, 0, 0, 0, 0, "R3");

        // R4 / R5 / R7: sweep snoop kind, exception, branch, memory op, retire,
        // and whether the store shares the event cycle.
        for (int ev = 0; ev < 128; ev++) begin
            logic [31:0] sa;
            logic        sv;
            logic        same;
            sv = (ev[1:0] != 2'b00);
            case (ev[1:0])
                2'd1:    sa = A;
                2'd2:    sa = A_WORD;
                default: sa = A_PAGE;
            endcase
            same = ev[6];
            step(1, A, 0, '0, 0, '0, 0, 0, 0, 0, "R1");
            step(0, '0, same, A, sv, sa, ev[2], ev[3], ev[4], ev[5],
                 (ev[1:0] == 2'd2) ? "R7" : (ev[1:0] != 0 ? "R4" : "R5"));
            if (!same) step(0, '0, 1, A, 0, '0, 0, 0, 0, 0, "R5");
            step(0, '0, 1, A, 0, '0, 0, 0, 0, 0, "R3");
        end

        // R7: same-page write kills only the page-granular instance
        step(1, A, 0, '0, 0, '0, 0, 0, 0, 0, "R7");
        step(0, '0, 0, '0, 1, A_WORD, 0, 0, 0, 0, "R7");
        step(0, '0, 1, A, 0, '0, 0, 0, 0, 0, "R7");
        chk("R7", "word instance survives same-page write", g_w, 1'b1);
        chk("R7", "page instance killed by same-page write", g_p, 1'b0);

        // R8: misalignment on either strobe
        for (int lo = 0; lo < 4; lo++) begin
            step(1, A | 32'(lo), 0, '0, 0, '0, 0, 0, 0, 0, "R8");
            step(0, '0, 1, A, 0, '0, 0, 0, 0, 0, "R8");
            step(1, A, 0, '0, 0, '0, 0, 0, 0, 0, "R8");
            step(0, '0, 1, A | 32'(lo), 0, '0, 0, 0, 0, 0, "R8");
        end

        // R6: retire window limits, including a pulse in the store's cycle
        for (int n = 511; n <= 513; n++) begin
            step(1, A, 0, '0, 0, '0, 0, 0, 0, 0, "R6");
            for (int k = 0; k < n; k++) step(0, '0, 0, '0, 0, '0, 0, 0, 0, 1, "R6");
            step(0, '0, 1, A, 0, '0, 0, 0, 0, 0, "R6");
        end
        step(1, A, 0, '0, 0, '0, 0, 0, 0, 0, "R6");
        for (int k = 0; k < 512; k++) step(0, '0, 0, '0, 0, '0, 0, 0, 0, 1, "R6");
        step(0, '0, 1, A, 0, '0, 0, 0, 0, 1, "R6");
        chk("R6", "513th retire in store cycle denies", g_w, 1'b0);

        // R9: reservation persists across long idle stretches
        step(1, A, 0, '0, 0, '0, 0, 0, 0, 0, "R9");
        for (int k = 0; k < 1000; k++) idle("R9");
        step(0, '0, 1, A, 0, '0, 0, 0, 0, 0, "R9");
        chk("R9", "grant after idle", g_w, 1'b1);

        // R10: store to another word fails and consumes the reservation
        step(1, A, 0, '0, 0, '0, 0, 0, 0, 0, "R10");
        step(0, '0, 1, A_WORD, 0, '0, 0, 0, 0, 0, "R10");
        step(0, '0, 1, A, 0, '0, 0, 0, 0, 0, "R10");
        chk("R10", "store after wrong-word store", g_w, 1'b0);

        // R12: load-linked wins over simultaneous kill events
        step(1, A, 0, '0, 0, '0, 0, 0, 0, 0, "R12");
        for (int k = 0; k < 600; k++) step(0, '0, 0, '0, 0, '0, 0, 0, 0, 1, "R12");
        step(1, A, 0, '0, 1, A, 1, 1, 1, 1, "R12");
        step(0, '0, 1, A, 0, '0, 0, 0, 0, 0, "R12");
        chk("R12", "grant after load-linked with kills", g_w, 1'b1);

        idle("R2");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule